// File: doc/BRIEF.md
# Page-Mode DRAM Controller with CAS-before-RAS Refresh

This block sits between a simple single-word host port and an asynchronous DRAM array that is 32 bits wide and has multiplexed addresses. A host request carries a 21-bit word address, a 32-bit write word and four byte enables. The controller splits the address into an 11-bit row (upper bits) and a 10-bit column (lower bits) and presents them in turn on one shared address bus. It drives active-low row strobes, one column strobe per byte lane and an active-low write enable. For reads it returns the captured word with a one-clock valid pulse.

After an access the row stays open. A later request to the same row then needs only a column cycle, with the row strobe held low. A request to another row first closes the open row and waits out the precharge time. A refresh timer raises a CAS-before-RAS refresh at a fixed cycle interval, and a pending refresh takes priority over new host requests. A row that has been open for a set maximum number of cycles is closed on its own. Every timing interval is a parameter counted in controller clocks. All pin outputs are registered.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `ras_n` is all ones, `cas_n` is 4'hF, `we_n` is 1 and `rd_valid` is 0. With no refresh pending, `req_ready` is 1 after reset.
- R2: When the row strobe falls for an access, `dram_addr` carries `req_addr[20:10]`. When the column strobes fall, `dram_addr` carries `req_addr[9:0]` with a zero in the top bit.
- R3: `cas_n[i]` serves data bits 8i+7..8i. A write pulls low exactly the lanes whose `req_be` bit is 1. A read pulls low all four lanes.
- R4: In a write, `we_n` goes low at least one clock before any column strobe falls and `dram_dq_oe` is 1 while the strobes are low. In a read, `we_n` stays high.
- R5: A read returns the last word written to that address, with each byte merged according to its byte enables. `rd_valid` is high for exactly one clock.
- R6: A request to the open row starts without a new row-strobe fall. Before every fall, the row strobe has been high for at least `T_RP` clocks.
- R7: The column strobes fall at least `T_RCD` clocks after the row strobe falls. In an access they stay low for exactly `T_CAS` clocks.
- R8: A refresh pulls all four column strobes low while the row strobe is high, and only then lets the row strobe fall. `we_n` is high during the refresh.
- R9: The gap between two refreshes, or between reset and the first refresh, never exceeds `REF_INTERVAL` plus a small bounded delay. That delay is at most one access in progress plus one precharge.
- R10: While a refresh is pending, `req_ready` is 0. An open row is closed, with precharge, before the refresh begins.
- R11: A row left idle is closed once it has been open for `T_RAS_MAX` clocks. The row strobe is never low for much longer than that bound.
- R12: The two row-strobe outputs always carry the same value.
- R13: `req_ready` drops in the clock after a request is accepted. While it is high, the column strobes and `we_n` are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address: row in [20:10], column in [9:0] |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte enables for writes, bit i covers bits 8i+7..8i |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 32 | Captured read word |
| ras_n | output | 2 | Active-low row strobes, driven together |
| cas_n | output | 4 | Active-low column strobe per byte lane |
| we_n | output | 1 | Active-low write enable |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 32 | Write data toward the array |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | 32 | Read data from the array |

## Verification
The bench attacks the mix of page hits and row misses. It does so with back-to-back accesses to a small set of rows, including row 2047 and column 1023. A design that trusted a stale open row would write into the wrong row, and the data comparison on the read-back catches it. Partial writes with random byte enables find lanes that are strobed by mistake or lanes that are merged wrongly. A pin-level array model flags any write whose enable arrives together with the column strobe instead of before it. Refreshes are timed from the pins while requests keep arriving, so a controller that let host traffic starve refresh, skipped the precharge before the CAS-before-RAS sequence, or ordered its strobes wrongly is caught. An idle period after an access checks that a forgotten open row is closed.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int LANES    = 4;
  localparam int LANE_W   = 8;
  localparam int DATA_W   = LANES * LANE_W;
  localparam int RAS_PINS = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_ROW,
    S_CSET,
    S_CLOW,
    S_CREC,
    S_RCAS,
    S_RRAS
  } dpcState_t;

  // Next-cycle pin values and datapath strobes from control
  typedef struct packed {
    logic             rasN;
    logic [LANES-1:0] casN;
    logic             weN;
    logic             colSel;
    logic             dqOe;
    logic             capture;
    logic             accept;
  } dpcCtl_t;

  function automatic int dpcMax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 1,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_CSR        = 1,
  parameter int T_RREF       = 3,
  parameter int T_RAS_MAX    = 500,
  parameter int REF_INTERVAL = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [LANES-1:0] reqBe,
  output logic             reqReady,
  output logic             refPending,
  output dpcCtl_t          ctl
);

  localparam int TMAX  = dpcMax(dpcMax(dpcMax(T_RP, T_RCD), dpcMax(T_CAS, T_CP)),
                                dpcMax(T_CSR, T_RREF));
  localparam int CNT_W = $clog2(TMAX) + 1;
  localparam int REF_W = $clog2(REF_INTERVAL) + 1;
  localparam int RAS_W = $clog2(T_RAS_MAX + 1) + 1;

  dpcState_t        state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             rowOpen, rowOpenNx;
  logic             hasPend, hasPendNx;
  logic [ROW_W-1:0] openRow;
  logic             pWrite;
  logic [LANES-1:0] pBe;
  logic [REF_W-1:0] refTimer;
  logic             refPend;
  logic [RAS_W-1:0] rasTimer;
  logic             rasExpired;
  logic             waitDone;
  logic             accept;

  assign rasExpired = rasTimer >= RAS_W'(T_RAS_MAX);
  assign waitDone   = (cnt == '0);
  assign reqReady   = (state == S_IDLE) && !refPend && !rasExpired;
  assign refPending = refPend;

  always_comb begin
    stateNx   = state;
    cntNx     = waitDone ? cnt : cnt - 1'b1;
    rowOpenNx = rowOpen;
    hasPendNx = hasPend;
    accept    = 1'b0;
    ctl       = '{rasN: 1'b1, casN: '1, weN: 1'b1, colSel: 1'b0,
                  dqOe: 1'b0, capture: 1'b0, accept: 1'b0};
    unique case (state)
      S_IDLE: begin
        ctl.rasN = !rowOpen;
        if (refPend || rasExpired) begin
          if (rowOpen) begin
            stateNx   = S_PRE;
            cntNx     = CNT_W'(T_RP - 1);
            rowOpenNx = 1'b0;
            hasPendNx = 1'b0;
          end else if (refPend) begin
            stateNx = S_RCAS;
            cntNx   = CNT_W'(T_CSR - 1);
          end
        end else if (reqValid) begin
          accept = 1'b1;
          if (rowOpen && (reqRow == openRow)) begin
            stateNx = S_CSET;
          end else if (rowOpen) begin
            stateNx   = S_PRE;
            cntNx     = CNT_W'(T_RP - 1);
            rowOpenNx = 1'b0;
            hasPendNx = 1'b1;
          end else begin
            stateNx = S_ROW;
            cntNx   = CNT_W'(T_RCD - 1);
          end
        end
      end
      S_PRE: begin
        if (waitDone) begin
          if (hasPend) begin
            stateNx   = S_ROW;
            cntNx     = CNT_W'(T_RCD - 1);
            hasPendNx = 1'b0;
          end else begin
            stateNx = S_IDLE;
          end
        end
      end
      S_ROW: begin
        ctl.rasN = 1'b0;
        if (waitDone) begin
          stateNx   = S_CSET;
          rowOpenNx = 1'b1;
        end
      end
      S_CSET: begin
        ctl.rasN   = 1'b0;
        ctl.colSel = 1'b1;
        ctl.weN    = !pWrite;
        ctl.dqOe   = pWrite;
        stateNx    = S_CLOW;
        cntNx      = CNT_W'(T_CAS - 1);
      end
      S_CLOW: begin
        ctl.rasN   = 1'b0;
        ctl.colSel = 1'b1;
        ctl.weN    = !pWrite;
        ctl.dqOe   = pWrite;
        ctl.casN   = pWrite ? ~pBe : '0;
        if (waitDone) begin
          stateNx = S_CREC;
          cntNx   = CNT_W'(T_CP - 1);
        end
      end
      S_CREC: begin
        ctl.rasN    = 1'b0;
        ctl.colSel  = 1'b1;
        ctl.dqOe    = pWrite;
        ctl.capture = !pWrite && (cnt == CNT_W'(T_CP - 1));
        if (waitDone) stateNx = S_IDLE;
      end
      S_RCAS: begin
        ctl.casN = '0;
        if (waitDone) begin
          stateNx = S_RRAS;
          cntNx   = CNT_W'(T_RREF - 1);
        end
      end
      S_RRAS: begin
        ctl.rasN = 1'b0;
        ctl.casN = '0;
        if (waitDone) begin
          stateNx   = S_PRE;
          cntNx     = CNT_W'(T_RP - 1);
          hasPendNx = 1'b0;
        end
      end
      default: stateNx = S_IDLE;
    endcase
    ctl.accept = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      rowOpen <= 1'b0;
      hasPend <= 1'b0;
      openRow <= '0;
      pWrite  <= 1'b0;
      pBe     <= '0;
    end else begin
      state   <= stateNx;
      cnt     <= cntNx;
      rowOpen <= rowOpenNx;
      hasPend <= hasPendNx;
      if (accept) begin
        openRow <= reqRow;
        pWrite  <= reqWrite;
        pBe     <= reqBe;
      end
    end
  end

  // Refresh interval timer and row-active limit timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refTimer <= '0;
      refPend  <= 1'b0;
      rasTimer <= '0;
    end else begin
      if (state == S_RCAS) refPend <= 1'b0;
      if (refTimer == REF_W'(REF_INTERVAL - 1)) begin
        refTimer <= '0;
        refPend  <= 1'b1;
      end else begin
        refTimer <= refTimer + 1'b1;
      end
      if (!rowOpen)         rasTimer <= '0;
      else if (!rasExpired) rasTimer <= rasTimer + 1'b1;
    end
  end

endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 10,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpcCtl_t             ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   dqIn,
  output logic [RAS_PINS-1:0] rasN,
  output logic [LANES-1:0]    casN,
  output logic                weN,
  output logic [ROW_W-1:0]    dramAddr,
  output logic [DATA_W-1:0]   dqOut,
  output logic                dqOe,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid
);

  logic [ADDR_W-1:0] addrLat;
  logic [DATA_W-1:0] wdatLat;
  logic [DATA_W-1:0] dqNx;
  logic [ROW_W-1:0]  addrNx;

  assign addrNx = ctl.colSel ? ROW_W'(addrLat[COL_W-1:0])
                             : addrLat[ADDR_W-1 -: ROW_W];

  // Per-lane write data: load on drive, otherwise hold
  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign dqNx[i*LANE_W +: LANE_W] = ctl.dqOe ? wdatLat[i*LANE_W +: LANE_W]
                                               : dqOut[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrLat  <= '0;
      wdatLat  <= '0;
      rasN     <= '1;
      casN     <= '1;
      weN      <= 1'b1;
      dramAddr <= '0;
      dqOut    <= '0;
      dqOe     <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (ctl.accept) begin
        addrLat <= reqAddr;
        wdatLat <= reqWdata;
      end
      rasN     <= {RAS_PINS{ctl.rasN}};
      casN     <= ctl.casN;
      weN      <= ctl.weN;
      dramAddr <= addrNx;
      dqOut    <= dqNx;
      dqOe     <= ctl.dqOe;
      rdValid  <= ctl.capture;
      if (ctl.capture) rdData <= dqIn;
    end
  end

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 10,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 1,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_CSR        = 1,
  parameter int T_RREF       = 3,
  parameter int T_RAS_MAX    = 500,
  parameter int REF_INTERVAL = 780,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [LANES-1:0]    req_be,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [RAS_PINS-1:0] ras_n,
  output logic [LANES-1:0]    cas_n,
  output logic                we_n,
  output logic [ROW_W-1:0]    dram_addr,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);

  dpcCtl_t ctl;
  logic    refPending;

  dpc_ctrl #(
    .ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
    .T_CSR(T_CSR), .T_RREF(T_RREF), .T_RAS_MAX(T_RAS_MAX),
    .REF_INTERVAL(REF_INTERVAL)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .reqValid(req_valid), .reqWrite(req_write),
    .reqRow(req_addr[ADDR_W-1 -: ROW_W]), .reqBe(req_be),
    .reqReady(req_ready), .refPending(refPending), .ctl(ctl)
  );

  dpc_datapath #(.ROW_W(ROW_W), .COL_W(COL_W)) uPath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqAddr(req_addr),
    .reqWdata(req_wdata), .dqIn(dram_dq_in), .rasN(ras_n), .casN(cas_n),
    .weN(we_n), .dramAddr(dram_addr), .dqOut(dram_dq_out), .dqOe(dram_dq_oe),
    .rdData(rd_data), .rdValid(rd_valid)
  );

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
  import dpc_pkg::*;
#(
  parameter int T_RP = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [RAS_PINS-1:0] rasN,
  input logic [LANES-1:0]    casN,
  input logic                weN,
  input logic                reqReady,
  input logic                rdValid,
  input logic                refPend
);

  logic [7:0] highCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     highCnt <= 8'(T_RP);
    else if (!rasN[0])              highCnt <= '0;
    else if (highCnt != 8'hFF)      highCnt <= highCnt + 1'b1;
  end

  // R12
  a_r12_ras_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rasN[0] == rasN[1]) else $error("row strobes differ");

  // R4
  a_r4_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!weN && casN != '1 && $past(casN) == '1) |-> !$past(weN))
    else $error("write enable not ahead of column strobe");

  // R8
  a_r8_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN[0]) |-> (casN == '1 || $past(casN) == '0))
    else $error("row strobe fell with bad column strobe state");

  // R5
  a_r5_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> !rdValid) else $error("read valid longer than one clock");

  // R10
  a_r10_ref_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    refPend |-> !reqReady) else $error("ready while refresh pending");

  // R13
  a_r13_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (casN == '1 && weN)) else $error("ready during active strobes");

  // R6
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN[0]) |-> highCnt >= 8'(T_RP)) else $error("precharge too short");

endmodule

bind dram_page_ctrl dpc_checker #(.T_RP(T_RP)) uChk (
  .clk(clk), .rst_n(rst_n), .rasN(ras_n), .casN(cas_n), .weN(we_n),
  .reqReady(req_ready), .rdValid(rd_valid), .refPend(refPending)
);

// File: tb/dram_page_ctrl_test.sv
`timescale 1ns/1ps
module dram_page_ctrl_test;

  localparam int P_RP = 2, P_RCD = 1, P_CAS = 2, P_CP = 1;
  localparam int P_RASMAX = 60, P_REF = 200;
  localparam int REF_SLACK = 40, RAS_SLACK = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  ras_n;
  logic [3:0]  cas_n;
  logic        we_n;
  logic [10:0] dram_addr;
  logic [31:0] dram_dq_out;
  logic        dram_dq_oe;
  logic [31:0] dram_dq_in = '0;

  dram_page_ctrl #(
    .T_RP(P_RP), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP),
    .T_RAS_MAX(P_RASMAX), .REF_INTERVAL(P_REF)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected memory, keyed by host word address
  logic [31:0] expMem [int unsigned];
  // Pin-level array model memory, keyed by latched row/column
  logic [31:0] mdlMem [int unsigned];

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] expRead(logic [20:0] a);
    return expMem.exists(32'(a)) ? expMem[32'(a)] : 32'h0;
  endfunction

  // Current transaction, seen by the model
  logic [20:0] curAddr = '0;
  logic [3:0]  curBe = '0;
  logic        curWrite = 1'b0;

  // Model state
  logic        prevRas = 1'b1, prevWe = 1'b1;
  logic [3:0]  prevCas = 4'hF;
  logic [10:0] rowLatch = '0;
  int          rasHigh = 100, rasLow = 0, casLow = 0, cyc = 0, lastRef = 0;
  int          refCount = 0, actCount = 0;
  bit          accCas = 0;

  always @(negedge clk) begin
    logic [3:0]  fell;
    int unsigned key;
    logic [31:0] w;
    if (!rst_n) begin
      prevRas = 1'b1; prevCas = 4'hF; prevWe = 1'b1;
      rasHigh = 100; rasLow = 0; casLow = 0; cyc = 0; lastRef = 0; accCas = 0;
    end else begin
      cyc++;
      fell = prevCas & ~cas_n;
      if (prevRas && !ras_n[0]) begin
        check(ras_n[1] == ras_n[0], "R12", "row strobe pair", 32'(ras_n), 32'h0);
        if (cas_n == 4'h0) begin
          check(prevCas == 4'h0, "R8", "column strobes before row", 32'(prevCas), 32'h0);
          check(we_n == 1'b1, "R8", "write enable in refresh", 32'(we_n), 32'h1);
          check(rasHigh >= P_RP, "R10", "precharge before refresh", 32'(rasHigh), 32'(P_RP));
          check(cyc - lastRef <= P_REF + REF_SLACK, "R9", "refresh gap",
                32'(cyc - lastRef), 32'(P_REF + REF_SLACK));
          lastRef = cyc;
          refCount++;
        end else begin
          check(cas_n == 4'hF, "R8", "row fall with partial column strobes", 32'(cas_n), 32'hF);
          check(rasHigh >= P_RP, "R6", "precharge before activate", 32'(rasHigh), 32'(P_RP));
          check(dram_addr == curAddr[20:10], "R2", "row address",
                32'(dram_addr), 32'(curAddr[20:10]));
          rowLatch = dram_addr;
          actCount++;
        end
      end
      if (!ras_n[0] && !prevRas && fell != 4'h0) begin
        accCas = 1;
        check(rasLow >= P_RCD, "R7", "row to column delay", 32'(rasLow), 32'(P_RCD));
        check(dram_addr == {1'b0, curAddr[9:0]}, "R2", "column address",
              32'(dram_addr), 32'({1'b0, curAddr[9:0]}));
        key = 32'({rowLatch, dram_addr[9:0]});
        w = mdlMem.exists(key) ? mdlMem[key] : 32'h0;
        if (!we_n) begin
          check(!prevWe, "R4", "early write enable", 32'(prevWe), 32'h0);
          check(dram_dq_oe, "R4", "data drive in write", 32'(dram_dq_oe), 32'h1);
          check(~cas_n == curBe, "R3", "write lanes", 32'(~cas_n), 32'(curBe));
          mdlMem[key] = merge(w, dram_dq_out, ~cas_n);
        end else begin
          check(!curWrite, "R4", "write enable missing in write", 32'(we_n), 32'h0);
          check(cas_n == 4'h0, "R3", "read lanes", 32'(cas_n), 32'h0);
          dram_dq_in = w;
        end
      end
      if (accCas && cas_n == 4'hF && prevCas != 4'hF) begin
        check(casLow == P_CAS, "R7", "column strobe width", 32'(casLow), 32'(P_CAS));
        accCas = 0;
      end
      if (!prevRas && ras_n[0])
        check(rasLow <= P_RASMAX + RAS_SLACK, "R11", "row active time",
              32'(rasLow), 32'(P_RASMAX + RAS_SLACK));
      rasHigh = ras_n[0] ? rasHigh + 1 : 0;
      rasLow  = !ras_n[0] ? rasLow + 1 : 0;
      casLow  = (cas_n != 4'hF) ? casLow + 1 : 0;
      prevRas = ras_n[0]; prevCas = cas_n; prevWe = we_n;
    end
  end

  task automatic doReq(input bit w, input logic [20:0] a, input logic [31:0] d,
                       input logic [3:0] be);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    curAddr = a; curBe = be; curWrite = w;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R13", "ready after accept", 32'(req_ready), 32'h0);
    if (w) begin
      expMem[32'(a)] = merge(expRead(a), d, be);
    end else begin
      n = 0;
      while (!rd_valid && n < 40) begin @(negedge clk); n++; end
      check(rd_valid, "R5", "read valid seen", 32'(rd_valid), 32'h1);
      check(rd_data == expRead(a), "R5", "read data", rd_data, expRead(a));
      @(negedge clk);
      check(!rd_valid, "R5", "read valid one clock", 32'(rd_valid), 32'h0);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int a0;
    logic [20:0] a;
    logic [10:0] rows [4];
    rows[0] = 11'd0; rows[1] = 11'd1; rows[2] = 11'd7; rows[3] = 11'd2047;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    check(ras_n == 2'b11 && cas_n == 4'hF && we_n && !rd_valid, "R1", "pins in reset",
          {ras_n, cas_n, we_n, rd_valid}, {2'b11, 4'hF, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check(ras_n == 2'b11 && cas_n == 4'hF && we_n && !rd_valid, "R1", "pins after reset",
          {ras_n, cas_n, we_n, rd_valid}, {2'b11, 4'hF, 1'b1, 1'b0});
    check(req_ready, "R1", "ready after reset", 32'(req_ready), 32'h1);

    // Full-word write and read back
    doReq(1, {11'd5, 10'd3}, 32'hA1B2C3D4, 4'hF);
    doReq(0, {11'd5, 10'd3}, '0, 4'h0);
    // Partial lanes merge (R3)
    doReq(1, {11'd5, 10'd3}, 32'h11223344, 4'b0101);
    doReq(0, {11'd5, 10'd3}, '0, 4'h0);
    doReq(1, {11'd5, 10'd3}, 32'hEEFF0099, 4'b1000);
    doReq(0, {11'd5, 10'd3}, '0, 4'h0);
    // Highest address corner
    doReq(1, {11'd2047, 10'd1023}, 32'hDEADBEEF, 4'hF);
    doReq(0, {11'd2047, 10'd1023}, '0, 4'h0);

    // Page hit right after a refresh (R6)
    a0 = refCount;
    while (refCount == a0) @(negedge clk);
    a0 = actCount;
    doReq(1, {11'd9, 10'd100}, 32'h0BADF00D, 4'hF);
    doReq(0, {11'd9, 10'd100}, '0, 4'h0);
    doReq(0, {11'd9, 10'd3}, '0, 4'h0);
    check(actCount - a0 == 1, "R6", "page hit without activate", 32'(actCount - a0), 32'h1);
    doReq(0, {11'd5, 10'd3}, '0, 4'h0);
    check(actCount - a0 == 2, "R6", "miss reactivates", 32'(actCount - a0), 32'h2);

    // Idle row closes (R11)
    repeat (P_RASMAX + 30) @(negedge clk);
    check(ras_n == 2'b11, "R11", "idle row closed", 32'(ras_n), 32'h3);

    // Random traffic over a few rows
    for (int i = 0; i < 400; i++) begin
      a = {rows[$urandom_range(3)], 10'($urandom_range(1023))};
      if (($urandom_range(7)) == 0) a[9:0] = ($urandom_range(1) != 0) ? 10'd1023 : 10'd0;
      if ($urandom_range(1) != 0)
        doReq(1, a, $urandom(), 4'($urandom_range(15, 1)));
      else
        doReq(0, a, '0, 4'h0);
    end

    check(refCount > 5, "R9", "refreshes observed", 32'(refCount), 32'h6);
    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule